// File: doc/BRIEF.md
# Paged memory window address translator

This block translates host memory addresses into card addresses for one card socket. It holds a small set of memory windows. Each window has a first page, a last page, a page offset and two flags. One flag picks attribute space instead of common space. The other flag picks a 16-bit data path. Pages are 4 KB. Only host address bits 23:12 are compared against the window bounds.

Software programs the windows through a byte-wide indirect register interface. It first writes an index, then writes or reads the data byte at that index. Bits 7:6 of the index must match the socket base, which is the chip number in bit 7 and the socket number in bit 6. Otherwise the access belongs to another socket and is ignored.

On each host access the block registers its result one cycle later: a hit flag, the card address and the two flags of the winning window. The card page is the host page plus the window offset, wrapped to a 26-bit card space. The low 12 address bits pass straight through.

Top module: `mwin_xlate`

## Requirements
- R1: Writing an index byte and then a data byte stores the data into the register at that index. Read data is registered and reflects the current index one cycle after the index is latched. Window w occupies local index 0x10+8*w. Its sub-offsets are: 0 = first page bits 7:0; 1 = bit 7 wide flag, bits 3:0 first page bits 11:8; 2 = last page bits 7:0; 3 = bits 3:0 last page bits 11:8; 4 = offset bits 7:0; 5 = bit 6 attribute flag, bits 5:0 offset bits 13:8. Unused bits read as zero. Local index 0x06 holds the window-enable bits, with bit w for window w.
- R2: An index whose bits 7:6 differ from the socket base reads as zero, and data writes to it change nothing.
- R3: Local indices with no register read as zero and ignore writes. These are all indices other than 0x06 below 0x10, sub-offsets 6 and 7 of a window, and windows beyond the configured count.
- R4: An enabled window matches when first page <= host page <= last page. The last page is inclusive.
- R5: A window whose enable bit is clear never matches.
- R6: Card address = ((host page + offset) mod 2^14) concatenated with host address bits 11:0.
- R7: On a hit, attr_sel and wide_sel carry the winning window's attribute and wide flags.
- R8: When several enabled windows match, the lowest-numbered one wins.
- R9: With no match, or no access, hit is low and card_addr, attr_sel and wide_sel are zero.
- R10: Results appear one clock after acc_valid. After reset all registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Latch host_wdata as the register index |
| dat_wr | input | 1 | Write host_wdata to the indexed register |
| host_wdata | input | 8 | Index or data byte from the host |
| host_rdata | output | 8 | Registered content of the indexed register |
| acc_valid | input | 1 | Host memory access strobe |
| acc_addr | input | 24 | Host memory address |
| hit | output | 1 | Registered: the access fell in an enabled window |
| card_addr | output | 26 | Registered translated card address |
| attr_sel | output | 1 | Registered attribute-space select |
| wide_sel | output | 1 | Registered 16-bit data-path select |

## Verification
The hardest case to reach from the ports is an access that falls in two windows at once while the lower window is later switched off. The stimulus programs overlapping windows 0 and 1, with different flags and an offset that wraps past the top of card space. It first checks that window 0 claims the overlap. It then clears only window 0's enable bit and repeats the same address, so that window 1 must now produce the wrapped address. Writes from a foreign socket index are placed just before an access, which shows through the translation that they altered nothing.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  localparam int SYS_AW   = 24;
  localparam int PG_SHIFT = 12;
  localparam int CARD_AW  = 26;
  localparam int SYS_PW   = SYS_AW - PG_SHIFT;   // host page bits
  localparam int CARD_PW  = CARD_AW - PG_SHIFT;  // card page bits
  localparam int SPAD_HI  = 15 - SYS_PW;         // pad in first-page high byte
  localparam int TPAD_HI  = 16 - SYS_PW;         // pad in last-page high byte
  localparam int OPAD_HI  = 15 - CARD_PW;        // pad in offset high byte

  typedef struct packed {
    logic [SYS_PW-1:0]  first;
    logic [SYS_PW-1:0]  last;
    logic [CARD_PW-1:0] off;
    logic               wide;
    logic               attr;
  } win_cfg_t;
endpackage

// File: rtl/mwt_regfile.sv
module mwt_regfile
  import mwt_pkg::*;
#(
  parameter int         NUM_WIN = 5,
  parameter logic [7:0] BASE    = 8'h40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      idx_wr,
  input  logic                      dat_wr,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg,
  output logic [NUM_WIN-1:0]        en
);
  localparam logic [5:0] EN_IDX = 6'h06;

  logic [7:0]         idx_q;
  logic [NUM_WIN-1:0] en_q;
  win_cfg_t           cfg_q [NUM_WIN];

  logic       ours;
  logic [5:0] loc;
  logic [2:0] wsel;
  logic       is_win;

  assign ours   = (idx_q[7:6] == BASE[7:6]);
  assign loc    = idx_q[5:0];
  assign wsel   = loc[5:3] - 3'd2;
  assign is_win = (loc[5:4] != 2'b00) && (int'(wsel) < NUM_WIN);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (dat_wr && ours && loc == EN_IDX) en_q <= wdata[NUM_WIN-1:0];
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (dat_wr && ours && is_win && int'(wsel) == g) begin
        case (loc[2:0])
          3'd0: cfg_q[g].first[7:0] <= wdata;
          3'd1: begin
            cfg_q[g].wide            <= wdata[7];
            cfg_q[g].first[SYS_PW-1:8] <= wdata[SYS_PW-9:0];
          end
          3'd2: cfg_q[g].last[7:0] <= wdata;
          3'd3: cfg_q[g].last[SYS_PW-1:8] <= wdata[SYS_PW-9:0];
          3'd4: cfg_q[g].off[7:0] <= wdata;
          3'd5: begin
            cfg_q[g].attr             <= wdata[6];
            cfg_q[g].off[CARD_PW-1:8] <= wdata[CARD_PW-9:0];
          end
          default: ;
        endcase
      end
    end
    assign cfg[g] = cfg_q[g];
  end

  logic [7:0] rd_next;
  win_cfg_t   rsel;

  always_comb begin
    rd_next = '0;
    rsel    = '0;
    if (ours) begin
      if (loc == EN_IDX) begin
        rd_next = {{(8-NUM_WIN){1'b0}}, en_q};
      end else if (is_win) begin
        for (int i = 0; i < NUM_WIN; i++)
          if (int'(wsel) == i) rsel = cfg_q[i];
        case (loc[2:0])
          3'd0: rd_next = rsel.first[7:0];
          3'd1: rd_next = {rsel.wide, {SPAD_HI{1'b0}}, rsel.first[SYS_PW-1:8]};
          3'd2: rd_next = rsel.last[7:0];
          3'd3: rd_next = {{TPAD_HI{1'b0}}, rsel.last[SYS_PW-1:8]};
          3'd4: rd_next = rsel.off[7:0];
          3'd5: rd_next = {{OPAD_HI{1'b0}}, rsel.attr, rsel.off[CARD_PW-1:8]};
          default: rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign en = en_q;
endmodule

// File: rtl/mwt_match.sv
module mwt_match
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic [SYS_PW-1:0]       page,
  input  win_cfg_t [NUM_WIN-1:0]  cfg,
  input  logic [NUM_WIN-1:0]      en,
  output logic                    found,
  output win_cfg_t                pick
);
  logic [NUM_WIN-1:0] m;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign m[g] = en[g] && (page >= cfg[g].first) && (page <= cfg[g].last);
  end

  // Scan downward so the lowest matching window is applied last.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (m[i]) begin
        found = 1'b1;
        pick  = cfg[i];
      end
    end
  end
endmodule

// File: rtl/mwin_xlate.sv
module mwin_xlate
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int CHIP_ID = 0,
  parameter int SOCK_ID = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idx_wr,
  input  logic               dat_wr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               acc_valid,
  input  logic [SYS_AW-1:0]  acc_addr,
  output logic               hit,
  output logic [CARD_AW-1:0] card_addr,
  output logic               attr_sel,
  output logic               wide_sel
);
  localparam logic [7:0] BASE = 8'((CHIP_ID << 7) | (SOCK_ID << 6));

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     en;
  logic                   found;
  win_cfg_t               pick;
  logic [CARD_PW-1:0]     cpage;

  mwt_regfile #(.NUM_WIN(NUM_WIN), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(host_wdata), .rdata(host_rdata), .cfg(cfg), .en(en)
  );

  mwt_match #(.NUM_WIN(NUM_WIN)) u_match (
    .page(acc_addr[SYS_AW-1:PG_SHIFT]), .cfg(cfg), .en(en),
    .found(found), .pick(pick)
  );

  // Sum truncates to the card page width: wrap modulo card space.
  assign cpage = CARD_PW'({{(CARD_PW-SYS_PW){1'b0}}, acc_addr[SYS_AW-1:PG_SHIFT]} + pick.off);

  always_ff @(posedge clk) begin
    if (rst || !(acc_valid && found)) begin
      hit       <= 1'b0;
      card_addr <= '0;
      attr_sel  <= 1'b0;
      wide_sel  <= 1'b0;
    end else begin
      hit       <= 1'b1;
      card_addr <= {cpage, acc_addr[PG_SHIFT-1:0]};
      attr_sel  <= pick.attr;
      wide_sel  <= pick.wide;
    end
  end
endmodule

// File: rtl/mwt_chk.sv
module mwt_chk
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int CHIP_ID = 0,
  parameter int SOCK_ID = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               idx_wr,
  input logic [7:0]         host_wdata,
  input logic [7:0]         host_rdata,
  input logic               acc_valid,
  input logic [SYS_AW-1:0]  acc_addr,
  input logic               hit,
  input logic [CARD_AW-1:0] card_addr,
  input logic               attr_sel,
  input logic               wide_sel
);
  localparam logic [1:0] SB = 2'(((CHIP_ID << 7) | (SOCK_ID << 6)) >> 6);

  logic [7:0] shadow_idx;
  always_ff @(posedge clk) begin
    if (rst)         shadow_idx <= '0;
    else if (idx_wr) shadow_idx <= host_wdata;
  end

  function automatic logic unimpl(input logic [7:0] ix);
    logic [5:0] l;
    l = ix[5:0];
    if (l < 6'h10) return (l != 6'h06);
    if (l[2:0] > 3'd5) return 1'b1;
    return (int'(l[5:3]) - 2) >= NUM_WIN;
  endfunction

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (card_addr == '0 && !attr_sel && !wide_sel));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !hit);

  assert_low_bits_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!hit || card_addr[PG_SHIFT-1:0] == $past(acc_addr[PG_SHIFT-1:0])));

  assert_foreign_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(shadow_idx[7:6]) != SB) |-> host_rdata == 8'h00);

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (rst)
    unimpl($past(shadow_idx)) |-> host_rdata == 8'h00);
endmodule

bind mwin_xlate mwt_chk #(.NUM_WIN(NUM_WIN), .CHIP_ID(CHIP_ID), .SOCK_ID(SOCK_ID)) u_chk (
  .clk(clk), .rst(rst), .idx_wr(idx_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .hit(hit), .card_addr(card_addr), .attr_sel(attr_sel), .wide_sel(wide_sel)
);

// File: tb/mwin_xlate_tb.sv
module mwin_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_wr = 1'b0, dat_wr = 1'b0, acc_valid = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [23:0] acc_addr = '0;
  logic        hit, attr_sel, wide_sel;
  logic [25:0] card_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  mwin_xlate u_dut (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .hit(hit),
    .card_addr(card_addr), .attr_sel(attr_sel), .wide_sel(wide_sel)
  );

  // Expected item: {hit, attr, wide, card_addr}
  typedef struct { logic [28:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic logic [28:0] xp(input logic h, input logic a,
                                     input logic w, input logic [25:0] c);
    return {h, a, w, c};
  endfunction

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
    @(negedge clk); idx_wr = 1'b1; host_wdata = ix;
    @(negedge clk); idx_wr = 1'b0; dat_wr = 1'b1; host_wdata = d;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] ix, input logic [7:0] e, input string tag);
    @(negedge clk); idx_wr = 1'b1; host_wdata = ix;
    @(negedge clk); idx_wr = 1'b0;
    @(negedge clk);
    checks++;
    if (host_rdata !== e) begin
      errors++;
      $display("FAIL %s: read idx %02h actual %02h expected %02h", tag, ix, host_rdata, e);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic [28:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); acc_valid = 1'b1; acc_addr = a;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  // Monitor: result registered at the edge that sampled acc_valid.
  logic vq = 1'b0;
  always @(posedge clk) vq <= acc_valid;
  always @(negedge clk) begin
    if (vq) begin
      exp_t it;
      logic [28:0] act;
      act = {hit, attr_sel, wide_sel, card_addr};
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected result %h", act);
      end else begin
        it = sb_q.pop_front();
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({hit, attr_sel, wide_sel, card_addr} !== 29'd0) begin
      errors++;
      $display("FAIL R10 reset outputs: actual %h expected 0", {hit, attr_sel, wide_sel, card_addr});
    end
    rd_chk(8'h46, 8'h00, "R10 enable reset");

    // Window 0: pages 0x100..0x10F, offset 0x200, wide
    wr_reg(8'h50, 8'h00); wr_reg(8'h51, 8'h81);
    wr_reg(8'h52, 8'h0F); wr_reg(8'h53, 8'h01);
    wr_reg(8'h54, 8'h00); wr_reg(8'h55, 8'h02);
    // Window 1: pages 0x105..0x200, offset 0x3F00, attribute
    wr_reg(8'h58, 8'h05); wr_reg(8'h59, 8'h01);
    wr_reg(8'h5A, 8'h00); wr_reg(8'h5B, 8'h02);
    wr_reg(8'h5C, 8'h00); wr_reg(8'h5D, 8'h7F);
    // Window 2: single page 0x300, offset 0x10
    wr_reg(8'h60, 8'h00); wr_reg(8'h61, 8'h03);
    wr_reg(8'h62, 8'h00); wr_reg(8'h63, 8'h03);
    wr_reg(8'h64, 8'h10); wr_reg(8'h65, 8'h00);

    access(24'h100ABC, xp(0, 0, 0, 26'h0), "R5 all windows disabled");
    wr_reg(8'h46, 8'h07);
    access(24'h100ABC, xp(1, 0, 1, 26'h0300ABC), "R4 R6 R7 window0 first page");
    access(24'h105123, xp(1, 0, 1, 26'h0305123), "R8 overlap lowest wins");
    access(24'h10FFFF, xp(1, 0, 1, 26'h030FFFF), "R4 inclusive last page");
    access(24'h110000, xp(1, 1, 0, 26'h0010000), "R6 R7 wrap attr window1");
    access(24'h300FFF, xp(1, 0, 0, 26'h0310FFF), "R4 single page window2");
    access(24'h301000, xp(0, 0, 0, 26'h0), "R9 past last page");
    access(24'h0FF000, xp(0, 0, 0, 26'h0), "R9 below first page");

    wr_reg(8'h46, 8'h06);
    access(24'h105123, xp(1, 1, 0, 26'h0005123), "R5 R8 window0 disabled");

    wr_reg(8'h06, 8'h00);   // foreign socket index
    wr_reg(8'h86, 8'h00);   // foreign chip index
    access(24'h105123, xp(1, 1, 0, 26'h0005123), "R2 foreign write ignored");
    rd_chk(8'h10, 8'h00, "R2 foreign read zero");
    rd_chk(8'h06, 8'h00, "R2 foreign enable read zero");

    rd_chk(8'h46, 8'h06, "R1 enable readback");
    rd_chk(8'h51, 8'h81, "R1 first-page high with wide");
    rd_chk(8'h55, 8'h02, "R1 offset high");
    rd_chk(8'h5D, 8'h7F, "R1 offset high with attr");
    wr_reg(8'h5B, 8'hFF);
    rd_chk(8'h5B, 8'h0F, "R1 unused bits of last-page high");
    wr_reg(8'h59, 8'hFF);
    rd_chk(8'h59, 8'h8F, "R1 unused bits of first-page high");

    wr_reg(8'h47, 8'hAA);
    rd_chk(8'h47, 8'h00, "R3 unimplemented low index");
    wr_reg(8'h56, 8'hAA);
    rd_chk(8'h56, 8'h00, "R3 window sub-offset 6");
    wr_reg(8'h78, 8'hAA);
    rd_chk(8'h78, 8'h00, "R3 window beyond count");
    rd_chk(8'h50, 8'h00, "R3 window0 untouched by stray writes");
    access(24'h300000, xp(1, 0, 0, 26'h0310000), "R3 window2 intact after stray writes");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10 scoreboard drain: actual %0d expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule